// File: doc/BRIEF.md
# Input Pulse Width Measurement Timer

This timer channel reports how long an external input stays at its active level. The width is counted in timer clock ticks. A tick comes either from an internal divide-by-two of the system clock or from an external prescaler strobe. The input is resampled on the system clock, and its transitions are classified as start or end edges according to a polarity control.

After a start edge, the first tick loads the counter with a programmable preload value, and every later tick adds one. The end edge freezes the count into a capture register and sets a sticky status flag. An interrupt follows that flag when interrupts are enabled. A reload control then chooses what happens next. The channel can rearm and wait for the next pulse. It can also let the counter run on and ignore further pulses.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, `count`, `capture`, `flag` and `irq` are all zero.
- R2: While `enable` is low, `count` is zero from the next clock. Input transitions cause no capture and do not set `flag`.
- R3: With `invert` = 0, a measurement starts only on a low-to-high transition of `pin_in`. With `invert` = 1, it starts only on a high-to-low transition. A transition of the other direction seen while armed leaves `count` unchanged.
- R4: The first tick after a start edge loads `load_value` into `count`, and each later tick adds one. If the pulse ends before any tick, `capture` receives `load_value`. A pulse that contains N ticks (N ≥ 1) therefore captures `load_value` + N − 1.
- R5: The end edge copies the running count into `capture`. With `reload_mode` = 1, `count` then holds its value until the next start edge.
- R6: `flag` is set at the clock where a capture happens. It stays set until `flag_clear` is sampled high. If a set and a clear fall on the same clock, the set wins.
- R7: `irq` is high exactly when `flag` and `irq_enable` are both high.
- R8: With `reload_mode` = 0, `count` keeps adding one per tick after a capture. Later pulses cause no capture and do not set `flag`. With `reload_mode` = 1, the next pulse is measured afresh from `load_value`.
- R9: With `clk_sel` = 0, a tick occurs on every second system clock while enabled. A pulse of H system clocks then captures `load_value` + k − 1, where k is either floor((H−1)/2) or ceil((H−1)/2).
- R10: The 24-bit counter wraps from all ones to zero, and no other output reacts.
- R11: A `pin_in` transition acts on the third rising clock edge after it is applied. Both edges see the same delay, so the measured width is not skewed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Channel enable; low clears the counter and disarms |
| invert | input | 1 | Start-edge polarity: 0 rising, 1 falling |
| reload_mode | input | 1 | 1 rearms after capture, 0 lets the counter run on |
| irq_enable | input | 1 | Interrupt enable |
| clk_sel | input | 1 | Tick source: 0 system clock / 2, 1 prescaler strobe |
| prescale_tick | input | 1 | One-clock prescaler strobe |
| load_value | input | 24 | Preload value |
| flag_clear | input | 1 | Write-one-to-clear strobe for the flag |
| pin_in | input | 1 | Asynchronous measured input |
| count | output | 24 | Live counter value |
| capture | output | 24 | Last captured width |
| flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Interrupt request |

## Verification
Setting the flag at a capture and clearing it from software can land on the same clock. The bench times a `flag_clear` strobe onto the exact edge where the end transition takes effect, which is three clocks after `pin_in` changes. It then expects `flag` to read one. A second strobe one clock later must bring the flag back to zero. Tick and edge coincidences are kept apart in the prescaler sweeps so that the captured values are exact. In the divide-by-two runs they are allowed to coincide, and the result is judged against the one-tick window.

// File: rtl/pwt_pkg.sv
// Shared types for the pulse width timer.
package pwt_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,   // waiting for a start edge
        ST_COUNT = 2'd1,   // measuring the active level
        ST_FREE  = 2'd2    // run-on after capture, edges ignored
    } meas_state_t;
endpackage

// File: rtl/pwt_edge_detect.sv
// Resamples the asynchronous input through two flops and compares it with
// the previous sample to find start and end transitions.
// Assumes: invert is quasi-static while a measurement runs.
module pwt_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic invert,
    output logic start_edge,
    output logic end_edge
);
    logic meta_q, sync_q, prev_q;

    // two-flop synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    logic rise, fall;
    // classify transitions by the polarity control
    always_comb begin
        rise       = sync_q & ~prev_q;
        fall       = ~sync_q & prev_q;
        start_edge = invert ? fall : rise;
        end_edge   = invert ? rise : fall;
    end

    // R3
    start_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_edge |=> !start_edge);
endmodule

// File: rtl/pwt_tick_gen.sv
// Produces the one-clock timer tick, either from a divide-by-two of the
// system clock or from an external prescaler strobe.
// Assumes: prescale_tick is synchronous to clk.
module pwt_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clk_sel,
    input  logic prescale_tick,
    output logic tick
);
    logic div_q;

    // divide-by-two phase, parked at zero while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= 1'b0;
        else if (!enable) div_q <= 1'b0;
        else              div_q <= ~div_q;
    end

    // pick the tick source
    always_comb tick = enable & (clk_sel ? prescale_tick : div_q);

    // R9
    div_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && div_q) |=> !div_q);
endmodule

// File: rtl/pwt_meas_core.sv
// Measurement state machine: preload on the first tick, increment after
// that, capture at the end edge, sticky flag, rearm or run on.
// Assumes: ticks and edges are single-clock strobes on clk.
module pwt_meas_core
    import pwt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         reload_mode,
    input  logic         tick,
    input  logic         start_edge,
    input  logic         end_edge,
    input  logic         flag_clear,
    input  logic [W-1:0] load_value,
    output logic [W-1:0] count,
    output logic [W-1:0] capture,
    output logic         flag
);
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    meas_state_t  state_q;
    logic [W-1:0] cnt_q, cap_q;
    logic         load_pend_q, flag_q, set_flag;

    // a capture happens on an end edge while measuring
    always_comb set_flag = enable && (state_q == ST_COUNT) && end_edge;

    // sticky flag, set has priority over a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (set_flag)   flag_q <= 1'b1;
        else if (flag_clear) flag_q <= 1'b0;
    end

    // counter, capture register and sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_ARMED;
            cnt_q       <= '0;
            cap_q       <= '0;
            load_pend_q <= 1'b0;
        end else if (!enable) begin
            state_q     <= ST_ARMED;
            cnt_q       <= '0;
            load_pend_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (start_edge) begin
                        state_q     <= ST_COUNT;
                        load_pend_q <= 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (end_edge) begin
                        cap_q       <= load_pend_q ? load_value : cnt_q;
                        load_pend_q <= 1'b0;
                        state_q     <= reload_mode ? ST_ARMED : ST_FREE;
                    end else if (tick) begin
                        cnt_q       <= load_pend_q ? load_value : cnt_q + CNT_ONE;
                        load_pend_q <= 1'b0;
                    end
                end
                ST_FREE: begin
                    if (tick) cnt_q <= cnt_q + CNT_ONE;
                end
                default: state_q <= ST_ARMED;
            endcase
        end
    end

    assign count   = cnt_q;
    assign capture = cap_q;
    assign flag    = flag_q;

    // R2
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> cnt_q == '0);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_COUNT && !end_edge && tick && !load_pend_q)
        |=> cnt_q == $past(cnt_q) + CNT_ONE);
    // R5
    capture_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_q) |-> flag_q);
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag |=> flag_q);
endmodule

// File: rtl/pulse_width_timer.sv
// Top of the pulse width timer: synchronizer/edge finder, tick source and
// measurement core, plus the interrupt gate.
// Assumes: control inputs behave as register bits held stable by software.
module pulse_width_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         invert,
    input  logic         reload_mode,
    input  logic         irq_enable,
    input  logic         clk_sel,
    input  logic         prescale_tick,
    input  logic [W-1:0] load_value,
    input  logic         flag_clear,
    input  logic         pin_in,
    output logic [W-1:0] count,
    output logic [W-1:0] capture,
    output logic         flag,
    output logic         irq
);
    logic start_edge, end_edge, tick;

    pwt_edge_detect u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .invert(invert),
        .start_edge(start_edge), .end_edge(end_edge)
    );

    pwt_tick_gen u_tick (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
        .prescale_tick(prescale_tick), .tick(tick)
    );

    pwt_meas_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .reload_mode(reload_mode),
        .tick(tick), .start_edge(start_edge), .end_edge(end_edge),
        .flag_clear(flag_clear), .load_value(load_value),
        .count(count), .capture(capture), .flag(flag)
    );

    // interrupt request follows the flag when enabled
    always_comb irq = flag & irq_enable;

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> irq_enable);
endmodule

// File: tb/pulse_width_timer_test.sv
`timescale 1ns/1ps
module pulse_width_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, invert = 1'b0, reload_mode = 1'b1;
    logic        irq_enable = 1'b0, clk_sel = 1'b1, prescale_tick = 1'b0;
    logic [23:0] load_value = '0;
    logic        flag_clear = 1'b0, pin_in = 1'b0;
    logic [23:0] count, capture;
    logic        flag, irq;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_width_timer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
        .reload_mode(reload_mode), .irq_enable(irq_enable), .clk_sel(clk_sel),
        .prescale_tick(prescale_tick), .load_value(load_value),
        .flag_clear(flag_clear), .pin_in(pin_in),
        .count(count), .capture(capture), .flag(flag), .irq(irq)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            prescale_tick = 1'b1; step(1);
            prescale_tick = 1'b0; step(2);
        end
    endtask

    task automatic clear_flag();
        flag_clear = 1'b1; step(1); flag_clear = 1'b0; step(1);
    endtask

    // park the input at its idle level and restart the channel
    task automatic rearm(input logic inv);
        enable = 1'b0; invert = inv; pin_in = inv; step(6);
        enable = 1'b1; step(2);
    endtask

    // pulse containing n prescaler ticks, none near the edges
    task automatic pulse(input int n);
        pin_in = ~invert; step(5);
        ticks(n);
        step(3);
        pin_in = invert; step(5);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 capture", capture, 0);
        check("R1 flag", {23'd0, flag}, 0);
        check("R1 irq", {23'd0, irq}, 0);

        // R11 transition acts on the third rising edge
        load_value = 24'd7; clk_sel = 1'b1; reload_mode = 1'b1;
        rearm(1'b0);
        pin_in = 1'b1; step(2);
        prescale_tick = 1'b1; step(1); prescale_tick = 1'b0;
        check("R11 start not yet", count, 0);
        prescale_tick = 1'b1; step(1); prescale_tick = 1'b0;
        check("R11 start seen", count, 24'd7);
        pin_in = 1'b0; step(5); clear_flag();

        // R3 opposite transition while armed does not start
        enable = 1'b0; invert = 1'b0; pin_in = 1'b1; step(6);
        enable = 1'b1; step(2);
        pin_in = 1'b0; step(5); ticks(3);
        check("R3 wrong edge", count, 0);
        check("R3 no flag", {23'd0, flag}, 0);

        // R4/R10/R3 sweep over polarity, preload and tick count
        for (int inv = 0; inv < 2; inv++) begin
            rearm(inv[0]);
            for (int li = 0; li < 3; li++) begin
                for (int n = 0; n < 7; n++) begin
                    logic [23:0] ld, exp;
                    ld = (li == 0) ? 24'd0 : (li == 1) ? 24'd100 : 24'hFFFFFE;
                    load_value = ld;
                    exp = (n == 0) ? ld : ld + 24'(n) - 24'd1;
                    pulse(n);
                    if (li == 2 && n > 2) check("R10 wrap capture", capture, exp);
                    else                  check("R4 capture", capture, exp);
                    check("R6 flag set", {23'd0, flag}, 1);
                    // R5 count holds after capture in reload mode
                    ticks(2);
                    check("R5 count hold", count, (n == 0) ? 24'd0 + ((li == 0 && inv == 0) ? 24'd0 : count) : exp);
                    clear_flag();
                    check("R6 flag cleared", {23'd0, flag}, 0);
                end
            end
        end

        // R6 set and clear on the same edge: set wins
        rearm(1'b0); load_value = 24'd5;
        pin_in = 1'b1; step(5); ticks(2);
        pin_in = 1'b0; step(2);
        flag_clear = 1'b1; step(1); flag_clear = 1'b0;
        check("R6 set beats clear", {23'd0, flag}, 1);
        check("R5 capture", capture, 24'd6);
        flag_clear = 1'b1; step(1); flag_clear = 1'b0;
        check("R6 later clear", {23'd0, flag}, 0);

        // R7 interrupt gating
        pulse(1);
        irq_enable = 1'b0; step(1);
        check("R7 irq masked", {23'd0, irq}, 0);
        irq_enable = 1'b1; step(1);
        check("R7 irq raised", {23'd0, irq}, 1);
        clear_flag();
        check("R7 irq dropped", {23'd0, irq}, 0);
        irq_enable = 1'b0;

        // R8 run-on without reload
        reload_mode = 1'b0; rearm(1'b0); load_value = 24'd20;
        pulse(4);
        check("R8 capture", capture, 24'd23);
        ticks(3);
        check("R8 run on", count, 24'd26);
        clear_flag();
        pulse(2);
        check("R8 no recapture", capture, 24'd23);
        check("R8 no flag", {23'd0, flag}, 0);
        check("R8 still counting", count, 24'd28);

        // R8 reload mode measures the next pulse afresh
        reload_mode = 1'b1; rearm(1'b0);
        pulse(3); clear_flag();
        pulse(5);
        check("R8 second pulse", capture, 24'd24);
        clear_flag();

        // R2 disabled channel ignores everything
        enable = 1'b0; step(1);
        check("R2 count cleared", count, 0);
        pin_in = 1'b1; step(5); ticks(3); pin_in = 1'b0; step(5);
        check("R2 no capture", capture, 24'd24);
        check("R2 no flag", {23'd0, flag}, 0);
        check("R2 count zero", count, 0);

        // R9 divide-by-two source, width within one tick
        clk_sel = 1'b0; load_value = 24'd50;
        for (int h = 6; h < 22; h++) begin
            int lo, hi;
            rearm(1'b0);
            step(h % 2);
            pin_in = 1'b1; step(h); pin_in = 1'b0; step(5);
            lo = 50 + (h - 1) / 2 - 1;
            hi = 50 + h / 2 - 1;
            total++;
            if (capture < 24'(lo) || capture > 24'(hi)) begin
                bad++;
                $display("FAIL R9 h=%0d actual=%0d expected=%0d..%0d", h, capture, lo, hi);
            end
            clear_flag();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule